// File: doc/BRIEF.md
# Reorder Buffer Retirement Controller

This block decides, every clock cycle, what leaves the reorder buffer of an out-of-order core that runs several hardware threads. It looks at a window of the oldest entries of each thread. For one chosen thread it retires a run of finished entries, up to a fixed width. It also tells the issue logic when an instruction that must not run speculatively has reached the oldest slot. It turns faults and post-retire flush requests into flush commands for the rest of the pipeline.

Each thread has its own small state machine. Faults wait a programmable number of cycles before their flush goes out. An instruction that asks for a flush after itself is retired first, and its flush follows on the next cycle. A flush is only finished once the buffer reports that it has finished removing entries. All outputs except the thread states are combinational views of the current cycle. The buffer is expected to drop the reported number of entries at the next clock edge.

Top module: `commit_retire_ctl`

## Requirements
- R1: A synchronous active-high reset puts every thread in Idle, with no retire, release or flush pending. Thread state codes are Running 0, Idle 1, RobSquashing 2, TrapPending 3, FetchTrapPending 4 and SquashAfterPending 5, in 3 bits per thread, with thread 0 in the low bits.
- R2: An Idle thread whose oldest entry is valid is Running from the next cycle. A Running thread whose oldest entry is not valid is Idle from the next cycle. A thread that is not Running retires nothing.
- R3: For the chosen thread, the retire count equals the number of leading window entries that are valid, complete and fault-free, up to the retire width. The count stops at the first entry that fails any of these tests.
- R4: When several Running threads have a retirable oldest entry, the choice rotates. After thread t retires, the search starts at thread t+1, wrapping round.
- R5: A Running thread whose oldest entry is valid, non-speculative, incomplete and fault-free gets exactly one release, carrying that entry's sequence number. It does not get a second release for the same entry.
- R6: At most one release is sent per cycle. The lowest-numbered eligible thread goes first, and the others follow on later cycles.
- R7: A retired entry marked flush-after is the last one retired that cycle. Its thread is in SquashAfterPending on the next cycle and retires nothing there.
- R8: In SquashAfterPending a flush is sent for that thread, with the flush-after entry's sequence number and cause code 3. The thread is RobSquashing on the following cycle.
- R9: A thread stays in RobSquashing until its removal-done input is high at a clock edge. It then becomes Idle.
- R10: A fault on a complete oldest entry of a Running thread puts the thread in TrapPending on the next cycle. After TRAP_LAT cycles there with no flush, the flush is sent with cause code 1 and the faulting entry's sequence number. Entries ahead of a faulting entry still retire.
- R11: A fault on an incomplete oldest entry follows the same timing through FetchTrapPending, with cause code 2.
- R12: At most one flush is sent per cycle. The lowest-numbered thread goes first, and the other thread keeps its state until it is granted. A flush and a retire for different threads can happen in the same cycle.
- R13: The overall status is 2'b01 (Active) when a retire or flush happens in the cycle, or when any thread is in states 2 to 5. Otherwise it is 2'b00 (Inactive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| headValid | input | NUM_THR*COMMIT_W | Window entry valid; entry i of thread t at bit t*COMMIT_W+i, entry 0 oldest |
| headDone | input | NUM_THR*COMMIT_W | Window entry has completed execution |
| headSqAfter | input | NUM_THR*COMMIT_W | Window entry requests a flush of everything younger once retired |
| headFault | input | NUM_THR*COMMIT_W | Window entry carries a fault |
| headSeq | input | NUM_THR*COMMIT_W*SEQ_W | Window entry sequence numbers, same ordering |
| headNonSpec | input | NUM_THR | Oldest entry of each thread is non-speculative |
| robSqDone | input | NUM_THR | Buffer has finished removing the flushed entries of the thread |
| commitValid | output | 1 | Entries retire this cycle |
| commitThread | output | TID_W | Thread that retires |
| commitCount | output | CNT_W | Number of entries retired |
| relValid | output | 1 | Non-speculative release this cycle |
| relThread | output | TID_W | Thread of the release |
| relSeq | output | SEQ_W | Sequence number released |
| squashValid | output | 1 | Flush command this cycle |
| squashThread | output | TID_W | Thread flushed |
| squashSeq | output | SEQ_W | Sequence number the flush is anchored at |
| squashCause | output | 2 | 1 trap, 2 fetch-side trap, 3 flush-after, 0 none |
| thrStatus | output | NUM_THR*3 | Per-thread state codes |
| overallStatus | output | 2 | 2'b01 Active, 2'b00 Inactive |

## Verification
A flush for one thread and a retire for another can land in the same cycle. They use separate selection logic, and a slip in either one would show as one output hiding the other. The bench provokes this by putting thread 0 into the trap wait while thread 1 is handed a full window of finished entries. It then checks, on the exact cycle the trap delay runs out, that the flush fields name thread 0 with the faulting sequence number and that the retire fields name thread 1 with a count of four. A second collision, two fetch-side traps that mature together, is judged by the order of the two flushes over consecutive cycles.

// File: rtl/commit_ctl_pkg.sv
package commit_ctl_pkg;

  // Per-thread retirement state, 3-bit codes visible at the top ports
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_ROBSQ   = 3'd2,
    ST_TRAP    = 3'd3,
    ST_FTRAP   = 3'd4,
    ST_SQAFTER = 3'd5
  } thrState_t;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic commitEn;
    logic squashEn;
  } ctlStrobe_t;

  localparam logic [1:0] CAUSE_NONE    = 2'd0;
  localparam logic [1:0] CAUSE_TRAP    = 2'd1;
  localparam logic [1:0] CAUSE_FETCH   = 2'd2;
  localparam logic [1:0] CAUSE_SQAFTER = 2'd3;

  localparam logic [1:0] OVR_INACTIVE = 2'd0;
  localparam logic [1:0] OVR_ACTIVE   = 2'd1;

endpackage

// File: rtl/commit_ctl_fsm.sv
module commit_ctl_fsm import commit_ctl_pkg::*; #(
  parameter int NUM_THR  = 2,
  parameter int TRAP_LAT = 3,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int LAT_W   = $clog2(TRAP_LAT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THR-1:0]     h0Valid,
  input  logic [NUM_THR-1:0]     h0Done,
  input  logic [NUM_THR-1:0]     h0Fault,
  input  logic [NUM_THR-1:0]     robSqDone,
  input  logic                   sqAfterHit,
  output ctlStrobe_t             strobe,
  output logic [TID_W-1:0]       commitTid,
  output logic [TID_W-1:0]       squashTid,
  output logic [NUM_THR-1:0]     runMask,
  output logic [1:0]             squashCause,
  output logic [NUM_THR*3-1:0]   thrStatus,
  output logic [1:0]             overallStatus
);

  thrState_t          st  [NUM_THR];
  logic [LAT_W-1:0]   lat [NUM_THR];
  logic [TID_W-1:0]   rrPtr;
  logic [NUM_THR-1:0] ready, sqDue, trapSeen, busy;

  function automatic int wrapIdx(input int base, input int step);
    return (base + step) % NUM_THR;
  endfunction

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign runMask[t]  = (st[t] == ST_RUN);
    assign trapSeen[t] = runMask[t] & h0Valid[t] & h0Fault[t];
    assign ready[t]    = runMask[t] & h0Valid[t] & h0Done[t] & ~h0Fault[t];
    assign sqDue[t]    = (st[t] == ST_SQAFTER) ||
                         (((st[t] == ST_TRAP) || (st[t] == ST_FTRAP)) && (lat[t] == '0));
    assign busy[t]     = !((st[t] == ST_RUN) || (st[t] == ST_IDLE));
    assign thrStatus[t*3 +: 3] = st[t];
  end

  // Retire thread rotates; flush grant goes to the lowest index
  always_comb begin
    strobe      = '0;
    commitTid   = '0;
    squashTid   = '0;
    squashCause = CAUSE_NONE;
    for (int k = 0; k < NUM_THR; k++) begin
      if (!strobe.commitEn && ready[wrapIdx(int'(rrPtr), k)]) begin
        strobe.commitEn = 1'b1;
        commitTid       = TID_W'(wrapIdx(int'(rrPtr), k));
      end
    end
    for (int k = NUM_THR - 1; k >= 0; k--) begin
      if (sqDue[k]) begin
        strobe.squashEn = 1'b1;
        squashTid       = TID_W'(k);
      end
    end
    if (strobe.squashEn) begin
      case (st[squashTid])
        ST_TRAP:    squashCause = CAUSE_TRAP;
        ST_FTRAP:   squashCause = CAUSE_FETCH;
        ST_SQAFTER: squashCause = CAUSE_SQAFTER;
        default:    squashCause = CAUSE_NONE;
      endcase
    end
  end

  assign overallStatus = (strobe.commitEn || strobe.squashEn || (|busy)) ? OVR_ACTIVE
                                                                         : OVR_INACTIVE;

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr <= '0;
    end else if (strobe.commitEn) begin
      rrPtr <= (commitTid == TID_W'(NUM_THR - 1)) ? '0 : commitTid + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NUM_THR; t++) begin
      if (rst) begin
        st[t]  <= ST_IDLE;
        lat[t] <= '0;
      end else begin
        case (st[t])
          ST_IDLE: if (h0Valid[t]) st[t] <= ST_RUN;
          ST_RUN: begin
            if (trapSeen[t]) begin
              st[t]  <= h0Done[t] ? ST_TRAP : ST_FTRAP;
              lat[t] <= LAT_W'(TRAP_LAT);
            end else if (strobe.commitEn && (commitTid == TID_W'(t)) && sqAfterHit) begin
              st[t] <= ST_SQAFTER;
            end else if (!h0Valid[t]) begin
              st[t] <= ST_IDLE;
            end
          end
          ST_TRAP, ST_FTRAP: begin
            if (lat[t] != '0) lat[t] <= lat[t] - 1'b1;
            else if (strobe.squashEn && (squashTid == TID_W'(t))) st[t] <= ST_ROBSQ;
          end
          ST_SQAFTER:
            if (strobe.squashEn && (squashTid == TID_W'(t))) st[t] <= ST_ROBSQ;
          ST_ROBSQ: if (robSqDone[t]) st[t] <= ST_IDLE;
          default: st[t] <= ST_IDLE;
        endcase
      end
    end
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
    // R1
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (st[t] == ST_IDLE));
    // R7
    p_sqafter_enter_r7: assert property (@(posedge clk) disable iff (rst)
      (strobe.commitEn && sqAfterHit && (commitTid == TID_W'(t))) |=> (st[t] == ST_SQAFTER));
    // R8
    p_flush_to_robsq_r8: assert property (@(posedge clk) disable iff (rst)
      (strobe.squashEn && (squashTid == TID_W'(t))) |=> (st[t] == ST_ROBSQ));
    // R9
    p_robsq_hold_r9: assert property (@(posedge clk) disable iff (rst)
      ((st[t] == ST_ROBSQ) && !robSqDone[t]) |=> (st[t] == ST_ROBSQ));
    // R10
    p_trap_countdown_r10: assert property (@(posedge clk) disable iff (rst)
      ((st[t] == ST_TRAP) && (lat[t] != '0)) |=>
        ((st[t] == ST_TRAP) && (lat[t] == $past(lat[t]) - 1'b1)));
  end

endmodule

// File: rtl/commit_ctl_dp.sv
module commit_ctl_dp import commit_ctl_pkg::*; #(
  parameter int NUM_THR  = 2,
  parameter int COMMIT_W = 4,
  parameter int SEQ_W    = 16,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int CNT_W   = $clog2(COMMIT_W + 1),
  localparam int SLOTS   = NUM_THR * COMMIT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS-1:0]       headValid,
  input  logic [SLOTS-1:0]       headDone,
  input  logic [SLOTS-1:0]       headSqAfter,
  input  logic [SLOTS-1:0]       headFault,
  input  logic [SLOTS*SEQ_W-1:0] headSeq,
  input  logic [NUM_THR-1:0]     h0NonSpec,
  input  ctlStrobe_t             strobe,
  input  logic [TID_W-1:0]       commitTid,
  input  logic [TID_W-1:0]       squashTid,
  input  logic [NUM_THR-1:0]     runMask,
  output logic [CNT_W-1:0]       commitCnt,
  output logic                   sqAfterHit,
  output logic                   relValid,
  output logic [TID_W-1:0]       relTid,
  output logic [SEQ_W-1:0]       relSeq,
  output logic [SEQ_W-1:0]       squashSeq
);

  logic [SEQ_W-1:0]   sqAfterSeq;
  logic [SEQ_W-1:0]   sqSeq [NUM_THR];
  logic [NUM_THR-1:0] released, relCand;

  // Leading-run scan over the chosen thread's window
  always_comb begin
    logic halt;
    int   slot;
    halt       = 1'b0;
    commitCnt  = '0;
    sqAfterHit = 1'b0;
    sqAfterSeq = '0;
    for (int i = 0; i < COMMIT_W; i++) begin
      slot = int'(commitTid) * COMMIT_W + i;
      if (strobe.commitEn && !halt) begin
        if (headValid[slot] && headDone[slot] && !headFault[slot]) begin
          commitCnt = commitCnt + 1'b1;
          if (headSqAfter[slot]) begin
            sqAfterHit = 1'b1;
            sqAfterSeq = headSeq[slot*SEQ_W +: SEQ_W];
            halt       = 1'b1;
          end
        end else begin
          halt = 1'b1;
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_rel
    assign relCand[t] = runMask[t] & headValid[t*COMMIT_W] & h0NonSpec[t] &
                        ~headDone[t*COMMIT_W] & ~headFault[t*COMMIT_W] & ~released[t];
  end

  always_comb begin
    relValid = 1'b0;
    relTid   = '0;
    for (int k = NUM_THR - 1; k >= 0; k--) begin
      if (relCand[k]) begin
        relValid = 1'b1;
        relTid   = TID_W'(k);
      end
    end
    relSeq = relValid ? headSeq[int'(relTid)*COMMIT_W*SEQ_W +: SEQ_W] : '0;
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NUM_THR; t++) begin
      if (rst) begin
        released[t] <= 1'b0;
        sqSeq[t]    <= '0;
      end else begin
        if (!runMask[t] || (strobe.commitEn && (commitTid == TID_W'(t))))
          released[t] <= 1'b0;
        else if (relValid && (relTid == TID_W'(t)))
          released[t] <= 1'b1;
        if (strobe.commitEn && sqAfterHit && (commitTid == TID_W'(t)))
          sqSeq[t] <= sqAfterSeq;
        else if (runMask[t])
          sqSeq[t] <= headSeq[t*COMMIT_W*SEQ_W +: SEQ_W];
      end
    end
  end

  assign squashSeq = strobe.squashEn ? sqSeq[squashTid] : '0;

  // R5
  p_release_once_r5: assert property (@(posedge clk) disable iff (rst)
    relValid |=> !(relValid && (relTid == $past(relTid)) && (relSeq == $past(relSeq))));
  // R3
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.commitEn |-> ((commitCnt != '0) && (commitCnt <= CNT_W'(COMMIT_W))));

endmodule

// File: rtl/commit_retire_ctl.sv
module commit_retire_ctl import commit_ctl_pkg::*; #(
  parameter int NUM_THR  = 2,
  parameter int COMMIT_W = 4,
  parameter int SEQ_W    = 16,
  parameter int TRAP_LAT = 3,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int CNT_W   = $clog2(COMMIT_W + 1),
  localparam int SLOTS   = NUM_THR * COMMIT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS-1:0]       headValid,
  input  logic [SLOTS-1:0]       headDone,
  input  logic [SLOTS-1:0]       headSqAfter,
  input  logic [SLOTS-1:0]       headFault,
  input  logic [SLOTS*SEQ_W-1:0] headSeq,
  input  logic [NUM_THR-1:0]     headNonSpec,
  input  logic [NUM_THR-1:0]     robSqDone,
  output logic                   commitValid,
  output logic [TID_W-1:0]       commitThread,
  output logic [CNT_W-1:0]       commitCount,
  output logic                   relValid,
  output logic [TID_W-1:0]       relThread,
  output logic [SEQ_W-1:0]       relSeq,
  output logic                   squashValid,
  output logic [TID_W-1:0]       squashThread,
  output logic [SEQ_W-1:0]       squashSeq,
  output logic [1:0]             squashCause,
  output logic [NUM_THR*3-1:0]   thrStatus,
  output logic [1:0]             overallStatus
);

  ctlStrobe_t         strobe;
  logic [NUM_THR-1:0] h0Valid, h0Done, h0Fault, runMask;
  logic               sqAfterHit;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_head
    assign h0Valid[t] = headValid[t*COMMIT_W];
    assign h0Done[t]  = headDone[t*COMMIT_W];
    assign h0Fault[t] = headFault[t*COMMIT_W];
  end

  commit_ctl_fsm #(.NUM_THR(NUM_THR), .TRAP_LAT(TRAP_LAT)) u_ctl (
    .clk(clk), .rst(rst),
    .h0Valid(h0Valid), .h0Done(h0Done), .h0Fault(h0Fault), .robSqDone(robSqDone),
    .sqAfterHit(sqAfterHit), .strobe(strobe),
    .commitTid(commitThread), .squashTid(squashThread), .runMask(runMask),
    .squashCause(squashCause), .thrStatus(thrStatus), .overallStatus(overallStatus)
  );

  commit_ctl_dp #(.NUM_THR(NUM_THR), .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W)) u_dp (
    .clk(clk), .rst(rst),
    .headValid(headValid), .headDone(headDone), .headSqAfter(headSqAfter),
    .headFault(headFault), .headSeq(headSeq), .h0NonSpec(headNonSpec),
    .strobe(strobe), .commitTid(commitThread), .squashTid(squashThread),
    .runMask(runMask), .commitCnt(commitCount), .sqAfterHit(sqAfterHit),
    .relValid(relValid), .relTid(relThread), .relSeq(relSeq), .squashSeq(squashSeq)
  );

  assign commitValid = strobe.commitEn;
  assign squashValid = strobe.squashEn;

endmodule

// File: tb/commit_retire_ctl_test.sv
module commit_retire_ctl_test;
  localparam int T = 2, W = 4, SW = 16, LAT = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [T*W-1:0]    hv = '0, hd = '0, hsa = '0, hf = '0;
  logic [T*W*SW-1:0] hseq = '0;
  logic [T-1:0]      hns = '0, sqDone = '0;
  logic commitValid, relValid, squashValid;
  logic [0:0] commitThread, relThread, squashThread;
  logic [2:0] commitCount;
  logic [SW-1:0] relSeq, squashSeq;
  logic [1:0] squashCause, overallStatus;
  logic [T*3-1:0] thrStatus;
  int checks = 0, errors = 0;
  bit finished = 0;

  commit_retire_ctl #(.NUM_THR(T), .COMMIT_W(W), .SEQ_W(SW), .TRAP_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .headValid(hv), .headDone(hd), .headSqAfter(hsa),
    .headFault(hf), .headSeq(hseq), .headNonSpec(hns), .robSqDone(sqDone),
    .commitValid(commitValid), .commitThread(commitThread), .commitCount(commitCount),
    .relValid(relValid), .relThread(relThread), .relSeq(relSeq),
    .squashValid(squashValid), .squashThread(squashThread), .squashSeq(squashSeq),
    .squashCause(squashCause), .thrStatus(thrStatus), .overallStatus(overallStatus));

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int stOf(int t);
    return int'(thrStatus[t*3 +: 3]);
  endfunction

  task automatic setEnt(int t, int i, bit v, bit d, bit s, bit f, logic [SW-1:0] q);
    hv[t*W+i] = v; hd[t*W+i] = d; hsa[t*W+i] = s; hf[t*W+i] = f;
    hseq[(t*W+i)*SW +: SW] = q;
  endtask

  task automatic clrThr(int t);
    for (int i = 0; i < W; i++) setEnt(t, i, 0, 0, 0, 0, '0);
    hns[t] = 1'b0;
  endtask

  function automatic int expCnt(logic [W-1:0] v, logic [W-1:0] d);
    int n = 0;
    for (int i = 0; i < W; i++) begin
      if (!(v[i] && d[i])) return n;
      n++;
    end
    return n;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    #2 rst = 1'b0; #1;
    // R1 reset state
    chk("R1", "thread0 state", stOf(0), 1);
    chk("R1", "thread1 state", stOf(1), 1);
    chk("R1", "no retire/release/flush", int'(commitValid | relValid | squashValid), 0);
    chk("R13", "overall inactive after reset", int'(overallStatus), 0);

    // R2 / R3 idle then running
    setEnt(0, 0, 1, 1, 0, 0, 16'h1); setEnt(0, 1, 1, 1, 0, 0, 16'h2);
    setEnt(0, 2, 1, 0, 0, 0, 16'h3); setEnt(0, 3, 1, 1, 0, 0, 16'h4);
    #1;
    chk("R2", "idle thread retires nothing", int'(commitValid), 0);
    tick(); #1;
    chk("R2", "thread0 running", stOf(0), 0);
    chk("R3", "count stops at incomplete", int'(commitCount), 2);
    chk("R13", "overall active on retire", int'(overallStatus), 1);

    // R3 random windows on thread 0
    for (int it = 0; it < 40; it++) begin
      logic [W-1:0] rv, rd;
      rv = W'($urandom); rd = W'($urandom) | W'($urandom);
      rv[0] = 1'b1;
      for (int i = 0; i < W; i++) setEnt(0, i, rv[i], rd[i], 0, 0, SW'(100 + it * W + i));
      #1;
      chk("R3", "random retire count", int'(commitCount), expCnt(rv, rd));
      chk("R3", "random retire valid", int'(commitValid), int'(expCnt(rv, rd) > 0));
      tick();
    end

    // R4 rotation
    for (int i = 0; i < W; i++) begin
      setEnt(0, i, 1, 1, 0, 0, SW'(16'h200 + i));
      setEnt(1, i, 1, 1, 0, 0, SW'(16'h300 + i));
    end
    #1;
    chk("R2", "thread1 still idle", stOf(1), 1);
    chk("R4", "only running thread retires", int'(commitThread), 0);
    tick(); #1;
    chk("R4", "rotation picks thread1", int'(commitThread), 1);
    chk("R3", "full window count", int'(commitCount), 4);
    tick(); #1;
    chk("R4", "rotation back to thread0", int'(commitThread), 0);
    tick(); #1;
    chk("R4", "rotation to thread1 again", int'(commitThread), 1);

    // R5 / R6 non-speculative release
    clrThr(0); clrThr(1);
    setEnt(0, 0, 1, 0, 0, 0, 16'h40); hns[0] = 1'b1;
    setEnt(1, 0, 1, 0, 0, 0, 16'h80); hns[1] = 1'b1;
    #1;
    chk("R6", "first release thread", int'(relValid ? relThread : 1'bx), 0);
    chk("R5", "release seq thread0", int'(relSeq), 16'h40);
    chk("R13", "overall inactive while waiting", int'(overallStatus), 0);
    tick(); #1;
    chk("R6", "second release thread", int'(relThread), 1);
    chk("R5", "release seq thread1", int'(relSeq), 16'h80);
    tick(); #1;
    chk("R5", "no repeated release", int'(relValid), 0);
    hd[0] = 1'b1; #1;
    chk("R3", "released entry retires", int'(commitCount), 1);

    // R7 / R8 / R9 flush-after
    clrThr(1); hns[0] = 1'b0;
    setEnt(0, 0, 1, 1, 0, 0, 16'h50); setEnt(0, 1, 1, 1, 1, 0, 16'h51);
    setEnt(0, 2, 1, 1, 0, 0, 16'h52); setEnt(0, 3, 1, 1, 0, 0, 16'h53);
    #1;
    chk("R7", "flush-after entry ends run", int'(commitCount), 2);
    tick(); #1;
    chk("R7", "thread0 squash-after pending", stOf(0), 5);
    chk("R2", "empty thread1 idle", stOf(1), 1);
    chk("R7", "no retire while pending", int'(commitValid), 0);
    chk("R8", "flush valid", int'(squashValid), 1);
    chk("R8", "flush seq", int'(squashSeq), 16'h51);
    chk("R8", "flush cause", int'(squashCause), 3);
    tick(); #1;
    chk("R8", "thread0 rob squashing", stOf(0), 2);
    chk("R13", "overall active while squashing", int'(overallStatus), 1);
    tick(); #1;
    chk("R9", "held in rob squashing", stOf(0), 2);
    sqDone[0] = 1'b1;
    tick(); #1;
    chk("R9", "idle after removal done", stOf(0), 1);
    sqDone[0] = 1'b0;

    // R10 / R12 trap with concurrent retire
    clrThr(0);
    setEnt(0, 0, 1, 1, 0, 0, 16'h60); setEnt(0, 1, 1, 1, 0, 1, 16'h61);
    setEnt(0, 2, 1, 1, 0, 0, 16'h62);
    tick(); #1;
    chk("R10", "entries before fault retire", int'(commitCount), 1);
    clrThr(0);
    setEnt(0, 0, 1, 1, 0, 1, 16'h61);
    for (int i = 0; i < W; i++) setEnt(1, i, 1, 1, 0, 0, SW'(16'h90 + i));
    #1;
    chk("R10", "faulting head not retired", int'(commitValid), 0);
    tick(); #1;
    chk("R10", "thread0 trap pending", stOf(0), 3);
    for (int c = 0; c < LAT - 1; c++) begin
      chk("R10", "no flush during trap wait", int'(squashValid), 0);
      tick(); #1;
    end
    chk("R10", "no flush on last wait cycle", int'(squashValid), 0);
    tick(); #1;
    chk("R10", "trap flush valid", int'(squashValid), 1);
    chk("R10", "trap flush seq", int'(squashSeq), 16'h61);
    chk("R10", "trap flush cause", int'(squashCause), 1);
    chk("R12", "flush thread", int'(squashThread), 0);
    chk("R12", "retire alongside flush thread", int'(commitValid ? commitThread : 1'bx), 1);
    chk("R12", "retire alongside flush count", int'(commitCount), 4);
    tick(); #1;
    chk("R10", "trap leads to rob squashing", stOf(0), 2);
    sqDone[0] = 1'b1;
    tick(); #1;
    sqDone[0] = 1'b0;

    // R11 / R12 two fetch-side traps maturing together
    clrThr(0); clrThr(1);
    setEnt(0, 0, 1, 0, 0, 0, 16'hB0); hns[0] = 1'b1;
    setEnt(1, 0, 1, 0, 0, 0, 16'hA0); hns[1] = 1'b1;
    tick();
    hns = '0;
    setEnt(0, 0, 1, 0, 0, 1, 16'h71);
    setEnt(1, 0, 1, 0, 0, 1, 16'h72);
    tick(); #1;
    chk("R11", "thread0 fetch-trap pending", stOf(0), 4);
    chk("R11", "thread1 fetch-trap pending", stOf(1), 4);
    repeat (LAT) tick();
    #1;
    chk("R12", "lower thread flushed first", int'(squashValid ? squashThread : 1'bx), 0);
    chk("R11", "fetch trap cause", int'(squashCause), 2);
    chk("R11", "fetch trap seq", int'(squashSeq), 16'h71);
    chk("R12", "loser keeps state", stOf(1), 4);
    tick(); #1;
    chk("R12", "second flush thread", int'(squashValid ? squashThread : 1'bx), 1);
    chk("R12", "second flush seq", int'(squashSeq), 16'h72);
    chk("R11", "second flush cause", int'(squashCause), 2);
    chk("R12", "thread0 squashing", stOf(0), 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule